// File: doc/BRIEF.md
# Circular Buffer Pointer Step

This block works out the next pointer value for a load or store that walks a circular buffer with post-increment addressing. A request carries the current 32-bit pointer, a signed step, a 32-bit modifier word and a 32-bit base register. The block adds the sign-extended step to the pointer and folds the sum back into the buffer window. The window is given either by the pointer's own aligned block or by the base register.

The modifier holds two fields. A 17-bit window length sits in bits 16:0 and a 4-bit size exponent K sits in bits 27:24. When K is zero and the length is four or more, the window starts at the base register. Otherwise the window starts at the pointer with its low K+2 bits cleared. Issuing the memory access and writing the pointer back belong to the surrounding pipeline.

Requests arrive on a valid/ready stream and results leave on another, through a single register stage. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result waiting with `out_ready` low stays unchanged, and no new request is taken until it leaves.

Top module: `circ_ptr_step`

## Requirements
- R1: Only modifier bits 16:0 (length) and 27:24 (exponent K) affect the result; bits 23:17 and 31:28 are ignored.
- R2: Aligned window (used unless R3 applies): lo = pointer AND NOT(2^(K+2)-1), hi = lo OR length.
- R3: When K = 0 and length >= 4, lo = base register and hi = base register + length (mod 2^32); with K = 0 and length < 4 the aligned window of R2 applies, with a mask of 3.
- R4: The step input is sign-extended to 32 bits, and the candidate is pointer + step modulo 2^32.
- R5: A candidate that is unsigned-greater-or-equal to hi yields candidate - length.
- R6: A candidate that is unsigned-below lo (and not covered by R5) yields candidate + length.
- R7: A candidate with lo <= candidate < hi is passed through unchanged; candidate = hi - 1 stays, and candidate = hi wraps.
- R8: While `out_valid` is high and `out_ready` low, `out_valid` and `out_ptr` hold, and `in_ready` is low.
- R9: After reset `out_valid` is low and `in_ready` is high.
- R10: A request accepted on a clock edge shows its result on `out_ptr` with `out_valid` high right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_ptr | input | 32 | Current pointer |
| in_step | input | OFF_W (16) | Signed step, two's complement |
| in_modifier | input | 32 | Length in 16:0, exponent K in 27:24 |
| in_base | input | 32 | Window start for base-register mode |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ptr | output | 32 | Wrapped pointer |

## Verification
The bench feeds hand-picked pointers to both window modes. Steps are chosen so that the candidate lands one below hi, exactly on hi, exactly on lo and one below lo. This separates the three fold outcomes and catches off-by-one errors in the comparisons. K = 0 with lengths of three and four shows which side of the mode boundary is taken. Negative steps test the sign extension, and modifiers with junk in their unused bits show that those bits are ignored. A stalled-consumer case tests that data is held and input is refused, and a seeded random sweep across all K values is compared against a model written inside the bench.

// File: rtl/circ_pkg.sv
package circ_pkg;
  localparam int ADDR_W      = 32;
  localparam int LEN_W       = 17;
  localparam int EXP_W       = 4;
  localparam int EXP_LSB     = 24;
  localparam int EXP_BIAS    = 2;
  localparam int MIN_BASELEN = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] len;
    logic [EXP_W-1:0]  k;
    logic              use_base;
  } mod_fields_t;

  typedef struct packed {
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
  } window_t;
endpackage

// File: rtl/circ_mod_decode.sv
module circ_mod_decode
  import circ_pkg::*;
(
  input  logic [LEN_W-1:0] len_field,
  input  logic [EXP_W-1:0] exp_field,
  output mod_fields_t      fields
);
  localparam logic [LEN_W-1:0] MinLen = LEN_W'(MIN_BASELEN);

  always_comb begin
    fields.len      = ADDR_W'(len_field);
    fields.k        = exp_field;
    fields.use_base = (exp_field == '0) && (len_field >= MinLen);
  end
endmodule

// File: rtl/circ_window.sv
module circ_window
  import circ_pkg::*;
(
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] base,
  input  mod_fields_t       fields,
  output window_t           win
);
  logic [ADDR_W-1:0] mask;
  int unsigned       shamt;

  always_comb begin
    shamt = 32'(fields.k) + EXP_BIAS;
    mask  = (ADDR_W'(1) << shamt) - ADDR_W'(1);
    if (fields.use_base) begin
      win.lo = base;
      win.hi = base + fields.len;
    end else begin
      win.lo = ptr & ~mask;
      win.hi = (ptr & ~mask) | fields.len;
    end
  end
endmodule

// File: rtl/circ_fold.sv
module circ_fold
  import circ_pkg::*;
(
  input  logic [ADDR_W-1:0] cand,
  input  window_t           win,
  input  logic [ADDR_W-1:0] len,
  output logic [ADDR_W-1:0] result
);
  logic above, below;

  always_comb begin
    above = cand >= win.hi;
    below = cand <  win.lo;
    if (above)      result = cand - len;
    else if (below) result = cand + len;
    else            result = cand;
  end
endmodule

// File: rtl/circ_ptr_step.sv
module circ_ptr_step
  import circ_pkg::*;
#(
  parameter int OFF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_ptr,
  input  logic [OFF_W-1:0]  in_step,
  input  logic [31:0]       in_modifier,
  input  logic [31:0]       in_base,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_ptr
);
  mod_fields_t       fields;
  window_t           win;
  logic [ADDR_W-1:0] step_ext, cand, folded;
  logic              accept;
  logic              unused_mod_bits;

  assign unused_mod_bits = ^{in_modifier[31:EXP_LSB+EXP_W],
                             in_modifier[EXP_LSB-1:LEN_W]};

  assign step_ext = ADDR_W'($signed(in_step));
  assign cand     = in_ptr + step_ext;

  circ_mod_decode u_dec (
    .len_field (in_modifier[LEN_W-1:0]),
    .exp_field (in_modifier[EXP_LSB +: EXP_W]),
    .fields    (fields)
  );

  circ_window u_win (
    .ptr    (in_ptr),
    .base   (in_base),
    .fields (fields),
    .win    (win)
  );

  circ_fold u_fold (
    .cand   (cand),
    .win    (win),
    .len    (fields.len),
    .result (folded)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_ptr   <= '0;
    end else begin
      if (accept)         out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
      if (accept)         out_ptr   <= folded;
    end
  end

  logic [ADDR_W-1:0] step_mag;
  logic              bounded_req;
  assign step_mag    = step_ext[ADDR_W-1] ? (~step_ext + 1'b1) : step_ext;
  assign bounded_req = fields.use_base && (win.hi > win.lo) &&
                       (in_ptr >= win.lo) && (in_ptr < win.hi) &&
                       (step_mag <= fields.len);

  // R8
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_ptr));

  // R8
  no_take_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R10
  result_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R5 R6 R7
  stays_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && bounded_req |=> (out_ptr >= $past(win.lo)) && (out_ptr < $past(win.hi)));
endmodule

// File: tb/sim_circ_ptr_step.sv
module sim_circ_ptr_step;
  localparam int CLK_PERIOD = 10;
  localparam int OFF_W      = 16;

  logic             clk = 0, rst_n = 0;
  logic             in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [31:0]      in_ptr = 0, in_modifier = 0, in_base = 0, out_ptr;
  logic [OFF_W-1:0] in_step = 0;
  int               n_checks = 0, n_fail = 0;
  bit               done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  circ_ptr_step #(.OFF_W(OFF_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ptr(in_ptr), .in_step(in_step), .in_modifier(in_modifier),
    .in_base(in_base), .out_valid(out_valid), .out_ready(out_ready),
    .out_ptr(out_ptr));

  function automatic logic [31:0] model(logic [31:0] p, logic [OFF_W-1:0] s,
                                        logic [31:0] m, logic [31:0] b);
    logic [31:0] len, lo, hi, c, msk;
    int k;
    len = {15'd0, m[16:0]};
    k   = int'(m[27:24]);
    c   = p + {{(32-OFF_W){s[OFF_W-1]}}, s};
    if (k == 0 && len >= 4) begin
      lo = b; hi = b + len;
    end else begin
      msk = 32'hFFFF_FFFF >> (30 - k);
      lo  = p & ~msk; hi = lo | len;
    end
    if (c >= hi)      return c - len;
    else if (c < lo)  return c + len;
    return c;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step_one(string req, logic [31:0] p, logic [OFF_W-1:0] s,
                          logic [31:0] m, logic [31:0] b, logic [31:0] exp);
    in_ptr = p; in_step = s; in_modifier = m; in_base = b; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_ptr, exp);
  endtask

  task automatic t_reset;
    check("R9 out_valid", {31'd0, out_valid}, 32'd0);
    check("R9 in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_aligned;
    step_one("R2 R5 aligned wrap down", 32'h1000_0008, 16'd4, 32'h0200_000C, 0, 32'h1000_0000);
    step_one("R2 R7 aligned inside", 32'h1000_0008, 16'd3, 32'h0200_000C, 0, 32'h1000_000B);
    step_one("R2 R6 aligned wrap up", 32'h1000_0002, 16'hFFFD, 32'h0200_000C, 0, 32'h1000_000B);
  endtask

  task automatic t_base;
    step_one("R3 R5 cand equals hi", 32'h2038, 16'd8, 32'h40, 32'h2000, 32'h2000);
    step_one("R3 R7 cand hi-1", 32'h2038, 16'd7, 32'h40, 32'h2000, 32'h203F);
    step_one("R3 R7 cand equals lo", 32'h2008, 16'hFFF8, 32'h40, 32'h2000, 32'h2000);
    step_one("R3 R6 cand lo-1", 32'h2000, 16'hFFFF, 32'h40, 32'h2000, 32'h203F);
  endtask

  task automatic t_mode_edge;
    step_one("R3 K0 len3 aligned inside", 32'h100, 16'd2, 32'h3, 32'h8000, 32'h102);
    step_one("R3 K0 len3 aligned wrap", 32'h100, 16'd3, 32'h3, 32'h8000, 32'h100);
    step_one("R3 K0 len4 base mode", 32'h8002, 16'd2, 32'h4, 32'h8000, 32'h8000);
  endtask

  task automatic t_sign;
    step_one("R4 negative step", 32'h2008, 16'hFFF0, 32'h40, 32'h2000, 32'h2038);
    step_one("R4 large positive", 32'h0, 16'h7FFF, 32'h0D00_0000, 0, 32'h7FFF - 32'h0);
  endtask

  task automatic t_ignored;
    step_one("R1 junk bits", 32'h2038, 16'd8, 32'hF0FE_0040, 32'h2000, 32'h2000);
    step_one("R1 junk bits inside", 32'h2038, 16'd7, 32'hF0FE_0040, 32'h2000, 32'h203F);
  endtask

  task automatic t_stall;
    out_ready = 0;
    step_one("R10 first result", 32'h2038, 16'd7, 32'h40, 32'h2000, 32'h203F);
    in_ptr = 32'h2000; in_step = 16'hFFFF; in_valid = 1;
    check("R8 in_ready low", {31'd0, in_ready}, 32'd0);
    repeat (2) @(negedge clk);
    check("R8 held data", out_ptr, 32'h203F);
    check("R8 held valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R8 R10 next result", out_ptr, 32'h203F);
    check("R10 valid after drain", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R9 drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_sweep;
    logic [31:0] p, m, b;
    logic [OFF_W-1:0] s;
    for (int i = 0; i < 400; i++) begin
      m = {4'h0, 4'($urandom_range(0, 15)), 7'd0, 17'($urandom_range(0, 300))};
      if (i % 3 == 0) m[27:24] = 4'd0;
      b = $urandom;
      p = (i % 2 == 0) ? b + 32'($urandom_range(0, 300)) : $urandom;
      s = OFF_W'($urandom_range(0, 1023)) - OFF_W'(512);
      step_one("R2 R3 R5 R6 R7 sweep", p, s, m, b, model(p, s, m, b));
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_aligned();
        t_base();
        t_mode_edge();
        t_sign();
        t_ignored();
        t_stall();
        t_sweep();
        done = 1;
      end
      begin
        repeat (20000) @(negedge clk);
        if (!done) begin
          n_checks++; n_fail++;
          $display("FAIL watchdog: actual hung expected done");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule